// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds a parameterised bank of 32-bit event counters. The default is four. Software programs the counters over a plain word-addressed register bus. Each counter looks at a wide vector of event inputs, organised as groups of 16 sub-event lines. A per-counter configuration word picks one group and ANDs it with a 16-bit mask. In any cycle where the result is nonzero, the counter steps by one.

Counting is qualified by three things:
- a single bank-wide run bit;
- a kernel-mode input, which is honoured only when the counter's configuration permits kernel counting;
- a 4-bit current level, which must not be above the counter's level threshold.

When a counter rolls over from all ones to zero, it latches a sticky overflow flag. If its interrupt enable is set, it also latches an interrupt flag. The shared interrupt line is the OR of all interrupt flags. Both flags are cleared by writing ones to them.

A special group code (1) turns a counter into the upper half of a cascade. It then steps whenever the counter with the next lower index rolls over. Counter 0 has no lower neighbour, so it never steps under that code.

Software typically preloads a negative count so that an interrupt fires after a chosen number of events.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, every register reads as zero and `irq_o` is low.
- R2: The run bit is bit 0 of the word at byte offset 0x000. While it is clear, no counter changes except through a bus write. A write to it takes effect from the following cycle.
- R3: Each counter has a configuration word at 0x100+4*i. Bits 12:8 pick a group, and group g is `ev_in[16*g+15:16*g]`. Bits 31:16 hold the mask. A counter steps by exactly one in each qualified cycle where (group AND mask) is nonzero, even when several sub-events are active together.
- R4: When `kern_mode` is high, a counter steps only if bit 3 of its configuration is set. A counter steps only when `cur_lvl` is less than or equal to configuration bits 7:4.
- R5: With group code 1, counter i (i>0) steps in each qualified cycle in which counter i-1 rolls over, and its event group inputs are ignored. Counter 0 never steps under code 1.
- R6: A rollover from 0xFFFFFFFF to 0 sets bit 0 of the status word at 0x180+4*i. If configuration bit 0 is set, the rollover also sets status bit 4. `irq_o` is high while any counter's status bit 4 is set.
- R7: Status bits 0 and 4 stay set until written with 1. Writing 0 leaves them unchanged. A rollover in the same cycle as a clearing write leaves the bit set.
- R8: The value word at 0x080+4*i is fully writable. A value write in the same cycle as a step stores the written data and causes no rollover.
- R9: Configuration reads return only bits 31:16, 12:4, 3 and 0; other bits read 0. Status reads return only bits 4 and 0. The run word returns only bit 0. Any address outside the mapped words, including counters beyond the bank size, reads 0. Writes to such addresses change nothing.
- R10: A counter whose configuration is written to zero stops stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (12) | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, from register state |
| ev_in | input | GROUPS*16 (512) | Event lines, 16 per group |
| kern_mode | input | 1 | Core is in kernel mode |
| cur_lvl | input | 4 | Current level compared with each threshold |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
Two collisions are provoked on purpose.

The first is a value write landing on a cycle in which the same counter steps. The bench enables counting and then writes the value word on the next cycle, with the event held active. It then overwrites a counter that is already at all ones. In that second case the event is dropped one cycle later, so that the only rollover chance is the suppressed one. The stored value and an empty status word decide the outcome.

The second is a rollover meeting a write-one-to-clear of the same status word. Here the bench expects the flag to survive.

A behavioural model judges every cycle: it computes value, flag and interrupt state from the requirements and compares the read port and `irq_o` against them.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int DW   = 32;
    localparam int SUBW = 16;
    localparam int SELW = 5;
    localparam int LVLW = 4;

    localparam logic [SELW-1:0] SEL_CHAIN = 5'd1;
    localparam logic [DW-1:0]   CTL_WMASK = 32'hFFFF_1FF9;

    localparam int FLAG_OVF_BIT = 0;
    localparam int FLAG_INT_BIT = 4;

    typedef struct packed {
        logic [SUBW-1:0] mask;
        logic [2:0]      rsv_hi;
        logic [SELW-1:0] sel;
        logic [LVLW-1:0] lvl;
        logic            kern;
        logic [1:0]      rsv_lo;
        logic            irq_en;
    } ctl_t;

    typedef enum logic [1:0] {
        RG_GLOB = 2'd0,
        RG_VAL  = 2'd1,
        RG_CTL  = 2'd2,
        RG_FLAG = 2'd3
    } region_e;

endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
    import evcnt_pkg::*;
#(
    parameter int N_CNT = 4,
    parameter int AW    = 12,
    parameter int IW    = 2
)
(
    input  logic [AW-1:0] addr,
    output logic          ok,
    output region_e       rg,
    output logic [IW-1:0] idx
);

    logic [4:0] slot;
    logic       upper_zero;
    logic       unused_lsb;

    assign slot       = addr[6:2];
    assign rg         = region_e'(addr[8:7]);
    assign idx        = slot[IW-1:0];
    assign unused_lsb = ^addr[1:0];

    if (AW > 9) begin : g_upper
        assign upper_zero = (addr[AW-1:9] == '0);
    end else begin : g_noupper
        assign upper_zero = 1'b1;
    end

    always_comb begin
        if (rg == RG_GLOB) ok = upper_zero && (slot == 5'd0);
        else               ok = upper_zero && (int'(slot) < N_CNT);
    end

endmodule

// File: rtl/evcnt_qual.sv
module evcnt_qual
    import evcnt_pkg::*;
#(
    parameter int GROUPS = 32
)
(
    input  ctl_t                   ctl,
    input  logic [GROUPS*SUBW-1:0] ev,
    input  logic                   prev_wrap,
    input  logic                   glob_en,
    input  logic                   kern_mode,
    input  logic [LVLW-1:0]        cur_lvl,
    output logic                   step
);

    logic [SUBW-1:0] grp;
    logic            hit;
    logic            priv_ok;
    logic            unused_fields;

    always_comb begin
        grp = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (ctl.sel == SELW'(g)) grp = ev[g*SUBW +: SUBW];
        end
    end

    always_comb begin
        if (ctl.sel == SEL_CHAIN) hit = prev_wrap;
        else                      hit = |(grp & ctl.mask);
    end

    assign priv_ok       = (!kern_mode || ctl.kern) && (cur_lvl <= ctl.lvl);
    assign step          = glob_en && priv_ok && hit;
    assign unused_fields = ^{ctl.rsv_hi, ctl.rsv_lo, ctl.irq_en};

endmodule

// File: rtl/evcnt_slot.sv
module evcnt_slot
    import evcnt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          wr_val,
    input  logic          wr_ctl,
    input  logic          wr_flag,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] val,
    output ctl_t          ctl,
    output logic          ovf,
    output logic          intf,
    output logic          wrap
);

    logic clr_ovf;
    logic clr_int;

    assign wrap    = step && !wr_val && (&val);
    assign clr_ovf = wr_flag && wdata[FLAG_OVF_BIT];
    assign clr_int = wr_flag && wdata[FLAG_INT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val  <= '0;
            ctl  <= '0;
            ovf  <= 1'b0;
            intf <= 1'b0;
        end else begin
            if (wr_val)    val <= wdata;
            else if (step) val <= val + 1'b1;
            if (wr_ctl)    ctl <= ctl_t'(wdata & CTL_WMASK);
            ovf  <= wrap || (ovf && !clr_ovf);
            intf <= (wrap && ctl.irq_en) || (intf && !clr_int);
        end
    end

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val |=> (val == $past(wdata)));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_val |=> ((val == $past(val)) || (val == $past(val) + 32'd1)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_val) |=> $stable(val));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

    assert_int_follows_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctl.irq_en) |=> (ovf && intf));

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int N_CNT  = 4,
    parameter int GROUPS = 32,
    parameter int AW     = 12
)
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [AW-1:0]          reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [GROUPS*16-1:0]   ev_in,
    input  logic                   kern_mode,
    input  logic [3:0]             cur_lvl,
    output logic                   irq_o
);

    localparam int IW = (N_CNT > 1) ? $clog2(N_CNT) : 1;

    logic          dec_ok;
    region_e       dec_rg;
    logic [IW-1:0] dec_idx;
    logic          glob_en;

    logic [N_CNT-1:0] wrap_v;
    logic [N_CNT-1:0] step_v;
    logic [N_CNT-1:0] intf_v;
    logic [DW-1:0]    val_v  [N_CNT];
    logic [DW-1:0]    ctl_v  [N_CNT];
    logic [DW-1:0]    flag_v [N_CNT];

    evcnt_decode #(.N_CNT(N_CNT), .AW(AW), .IW(IW)) u_decode (
        .addr (reg_addr),
        .ok   (dec_ok),
        .rg   (dec_rg),
        .idx  (dec_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   glob_en <= 1'b0;
        else if (reg_wr && dec_ok && dec_rg == RG_GLOB) glob_en <= reg_wdata[0];
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        logic prev_w;
        logic hit_sel;
        logic wr_v, wr_c, wr_f;
        logic [DW-1:0] val_w;
        ctl_t ctl_w;
        logic ovf_w, int_w;

        assign hit_sel = reg_wr && dec_ok && (dec_idx == IW'(i));
        assign wr_v    = hit_sel && (dec_rg == RG_VAL);
        assign wr_c    = hit_sel && (dec_rg == RG_CTL);
        assign wr_f    = hit_sel && (dec_rg == RG_FLAG);

        if (i == 0) begin : g_head
            assign prev_w = 1'b0;
        end else begin : g_link
            assign prev_w = wrap_v[i-1];
        end

        evcnt_qual #(.GROUPS(GROUPS)) u_qual (
            .ctl       (ctl_w),
            .ev        (ev_in),
            .prev_wrap (prev_w),
            .glob_en   (glob_en),
            .kern_mode (kern_mode),
            .cur_lvl   (cur_lvl),
            .step      (step_v[i])
        );

        evcnt_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step_v[i]),
            .wr_val  (wr_v),
            .wr_ctl  (wr_c),
            .wr_flag (wr_f),
            .wdata   (reg_wdata),
            .val     (val_w),
            .ctl     (ctl_w),
            .ovf     (ovf_w),
            .intf    (int_w),
            .wrap    (wrap_v[i])
        );

        assign val_v[i]  = val_w;
        assign ctl_v[i]  = DW'(ctl_w);
        assign flag_v[i] = {27'b0, int_w, 3'b0, ovf_w};
        assign intf_v[i] = int_w;
    end

    always_comb begin
        reg_rdata = '0;
        if (dec_ok) begin
            unique case (dec_rg)
                RG_GLOB: reg_rdata = {31'b0, glob_en};
                RG_VAL:  reg_rdata = val_v[dec_idx];
                RG_CTL:  reg_rdata = ctl_v[dec_idx];
                RG_FLAG: reg_rdata = flag_v[dec_idx];
            endcase
        end
    end

    assign irq_o = |intf_v;

    assert_run_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (step_v == '0));

    assert_head_no_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_v[0][12:8] == SEL_CHAIN) |-> !step_v[0]);

endmodule

// File: tb/evcnt_bank_bench.sv
module evcnt_bank_bench;

    localparam int N  = 4;
    localparam int GR = 32;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [GR*16-1:0] ev = '0;
    logic          kern = 1'b0;
    logic [3:0]    lvl = 4'd0;
    logic          irq;

    evcnt_bank u_evcnt_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_in     (ev),
        .kern_mode (kern),
        .cur_lvl   (lvl),
        .irq_o     (irq)
    );

    int    total = 0;
    int    bad   = 0;
    string tag   = "R1";
    bit    done  = 0;

    function automatic logic [AW-1:0] va(int i); return AW'(32'h080 + 4*i); endfunction
    function automatic logic [AW-1:0] ca(int i); return AW'(32'h100 + 4*i); endfunction
    function automatic logic [AW-1:0] fa(int i); return AW'(32'h180 + 4*i); endfunction

    // behavioural reference state
    logic [31:0] m_val [N];
    logic [31:0] m_ctl [N];
    logic        m_ovf [N];
    logic        m_int [N];
    logic        m_gen;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_val[i] = 0; m_ctl[i] = 0; m_ovf[i] = 0; m_int[i] = 0;
            end
            m_gen = 0;
        end else begin
            bit pw;
            pw = 0;
            for (int i = 0; i < N; i++) begin
                bit hit, ok, wv, wc, wf, wrapped;
                int sel;
                logic [31:0] old;
                old = m_val[i];
                sel = int'(m_ctl[i][12:8]);
                if (sel == 1)       hit = (i > 0) && pw;
                else if (sel < GR)  hit = ((ev[sel*16 +: 16] & m_ctl[i][31:16]) != 0);
                else                hit = 0;
                ok = m_gen && (!kern || m_ctl[i][3]) && (lvl <= m_ctl[i][7:4]);
                wv = reg_wr && (reg_addr == va(i));
                wc = reg_wr && (reg_addr == ca(i));
                wf = reg_wr && (reg_addr == fa(i));
                wrapped = !wv && ok && hit && (old == 32'hFFFF_FFFF);
                if (wv)            m_val[i] = reg_wdata;
                else if (ok && hit) m_val[i] = old + 1;
                m_ovf[i] = wrapped || (m_ovf[i] && !(wf && reg_wdata[0]));
                m_int[i] = (wrapped && m_ctl[i][0]) || (m_int[i] && !(wf && reg_wdata[4]));
                if (wc) m_ctl[i] = reg_wdata & 32'hFFFF_1FF9;
                pw = wrapped;
            end
            if (reg_wr && reg_addr == '0) m_gen = reg_wdata[0];
        end
    end

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        int s;
        s = int'(a[6:2]);
        if (a[AW-1:9] != 0) return 0;
        case (a[8:7])
            2'd0:    return (s == 0) ? {31'b0, m_gen} : 32'h0;
            2'd1:    return (s < N) ? m_val[s] : 32'h0;
            2'd2:    return (s < N) ? m_ctl[s] : 32'h0;
            default: return (s < N) ? {27'b0, m_int[s], 3'b0, m_ovf[s]} : 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        logic r;
        r = 0;
        for (int i = 0; i < N; i++) r = r | m_int[i];
        return r;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        check(reg_rdata, m_read(reg_addr), {tag, " model rdata"});
        check({31'b0, irq}, {31'b0, m_irq()}, {tag, " model irq (R6)"});
        reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string t);
        cyc(1'b0, a, 32'h0);
        #1;
        check(reg_rdata, exp, t);
    endtask

    task automatic run(input int k);
        wr('0, 32'h1);
        repeat (k) cyc(1'b0, '0, 32'h0);
        wr('0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ca(0), 32'h0, "R1 ctl0");
        rd(va(2), 32'h0, "R1 val2");
        rd('0, 32'h0, "R1 run word");
        check({31'b0, irq}, 32'h0, "R1 irq");

        // R2 run bit gates counting
        tag = "R2";
        wr(ca(0), 32'h0001_00F0);
        ev[0] = 1'b1;
        repeat (5) cyc(1'b0, '0, 32'h0);
        rd(va(0), 32'h0, "R2 held while off");

        // R3 counting, single step with many sub-events
        tag = "R3";
        run(9);
        rd(va(0), 32'd10, "R3 cycle count");
        wr(va(0), 32'h0);
        wr(ca(0), 32'hFFFF_00F0);
        ev[15:0] = 16'hFFFF;
        run(4);
        rd(va(0), 32'd5, "R3 multi sub-event");

        // R4 privilege and level filter
        tag = "R4";
        wr(va(0), 32'h0);
        wr(ca(0), 32'h0001_00F0);
        ev[15:0] = 16'h0001;
        kern = 1'b1;
        run(3);
        rd(va(0), 32'd0, "R4 kernel blocked");
        wr(ca(0), 32'h0001_00F8);
        run(3);
        rd(va(0), 32'd4, "R4 kernel allowed");
        kern = 1'b0;
        wr(ca(0), 32'h0001_0020);
        lvl = 4'd3;
        run(3);
        rd(va(0), 32'd4, "R4 level above threshold");
        lvl = 4'd2;
        run(3);
        rd(va(0), 32'd8, "R4 level equal");

        // R5 chaining
        tag = "R5";
        lvl = 4'd0;
        wr(va(0), 32'hFFFF_FFFE);
        wr(ca(0), 32'h0001_00F0);
        wr(ca(1), 32'hFFFF_01F0);
        wr(va(1), 32'h0);
        ev[31:16] = 16'hFFFF;
        run(3);
        rd(va(0), 32'd2, "R5 lower counter");
        rd(va(1), 32'd1, "R5 chained step once");
        wr(ca(0), 32'h0000_01F0);
        run(3);
        rd(va(0), 32'd2, "R5 counter0 no chain");
        rd(va(1), 32'd1, "R5 chained idle");

        // R6 overflow and interrupt flags
        tag = "R6";
        rd(fa(0), 32'h01, "R6 overflow without irq enable");
        check({31'b0, irq}, 32'h0, "R6 irq low");
        wr(ca(2), 32'h0001_00F1);
        wr(va(2), 32'hFFFF_FFFF);
        run(0);
        rd(fa(2), 32'h11, "R6 both flags");
        rd(va(2), 32'h0, "R6 wrapped value");
        check({31'b0, irq}, 32'h1, "R6 irq high");

        // R7 write-one-to-clear
        tag = "R7";
        wr(fa(2), 32'h0);
        rd(fa(2), 32'h11, "R7 zero write keeps");
        wr(fa(2), 32'h1);
        rd(fa(2), 32'h10, "R7 clear overflow only");
        check({31'b0, irq}, 32'h1, "R7 irq still high");
        wr(fa(2), 32'h10);
        rd(fa(2), 32'h0, "R7 clear interrupt");
        check({31'b0, irq}, 32'h0, "R7 irq low");
        wr(va(2), 32'hFFFF_FFFF);
        wr('0, 32'h1);
        wr(fa(2), 32'h11);
        wr('0, 32'h0);
        rd(fa(2), 32'h11, "R7 set beats clear");
        rd(va(2), 32'h1, "R7 value after collision");
        wr(fa(2), 32'h11);

        // R8 write wins over step
        tag = "R8";
        wr('0, 32'h1);
        wr(va(2), 32'h100);
        wr('0, 32'h0);
        rd(va(2), 32'h101, "R8 written value kept");
        wr(va(2), 32'hFFFF_FFFF);
        wr('0, 32'h1);
        wr(va(2), 32'hFFFF_FFFF);
        @(posedge clk);
        #1 ev[0] = 1'b0;
        wr('0, 32'h0);
        rd(va(2), 32'hFFFF_FFFF, "R8 no step on write");
        rd(fa(2), 32'h0, "R8 no rollover on write");

        // R9 map and field masking
        tag = "R9";
        rd(AW'(12'h090), 32'h0, "R9 absent counter");
        rd(AW'(12'h200), 32'h0, "R9 above map");
        rd(AW'(12'h004), 32'h0, "R9 hole near run word");
        wr(AW'(12'h090), 32'h1234_5678);
        rd(va(0), 32'd2, "R9 absent write ignored");
        wr(ca(3), 32'hFFFF_FFFF);
        rd(ca(3), 32'hFFFF_1FF9, "R9 config bits");
        wr(fa(3), 32'hFFFF_FFFF);
        rd(fa(3), 32'h0, "R9 status bits");
        wr('0, 32'hFFFF_FFFF);
        rd('0, 32'h1, "R9 run bit only");
        wr('0, 32'h0);

        // R10 zero config stops
        tag = "R10";
        wr(ca(0), 32'h0001_00F0);
        ev[0] = 1'b1;
        run(2);
        rd(va(0), 32'd5, "R10 counting");
        wr(ca(0), 32'h0);
        run(2);
        rd(va(0), 32'd5, "R10 stopped");

        cyc(1'b0, '0, 32'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL %s watchdog act=hung exp=finished", tag);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule